// File: doc/BRIEF.md
# Step-Down Regulator Start-Up and Protection Sequencer

This block is the digital supervisor of a synchronous step-down converter. It decides when the power stage may switch, what loop reference the error amplifier sees, when the output capacitor is bled to ground, and whether the oscillator must slow down. Its inputs are the enable pin, a supply-good flag from the undervoltage comparator, an over-temperature flag, and a flag that is high while the feedback node sits below about 0.2 V. Its outputs are a digital reference code for an external converter, a switching permit, a discharge request and a divide-by-three select for the oscillator.

The states and their transitions are as follows. OFF (shutdown, discharge on) moves to WAKE when the synchronized enable is high, the supply is good and the die is cool. WAKE holds for `WAKE_CLKS` clocks while the reference settles, then moves to RAMP. RAMP raises the reference code from zero by one step every `STEP_CLKS` clocks. When the code is at full scale, RAMP moves to RUN. From WAKE, RAMP or RUN, loss of enable or of supply returns to OFF, and over-temperature moves to HOT. HOT (thermal shutdown, discharge on) returns to OFF if enable or supply is lost. Otherwise it moves straight to RAMP with the code at zero once the die has cooled. The comparator flags are taken to be already synchronous to `clk`, with their analog hysteresis applied upstream.

Top module: `buck_seq_ctrl`

## Requirements
- R1: After reset with enable low, `sw_allow`=0, `dis_en`=1, `osc_div3`=0 and `ref_code`=0.
- R2: A rising `en_pin` is sampled through two flops. When the synchronized enable is high, the supply is good and the die is cool, the block enters WAKE on the next clock. WAKE lasts exactly `WAKE_CLKS` clocks, and during it `sw_allow`=0, `dis_en`=0 and `ref_code`=0.
- R3: In RAMP, `sw_allow`=1. `ref_code` starts at 0, rises by exactly 1 every `STEP_CLKS` clocks and never falls. With the defaults, the code reaches k on the clock 4k+1 counted from the edge that entered RAMP, where that entry edge is clock 1.
- R4: The code saturates at all-ones (255 by default). The block then enters RUN and holds the code there.
- R5: In the cycle the synchronized enable is seen low (two clocks after `en_pin` falls), `sw_allow` goes to 0, `dis_en` to 1 and `ref_code` to 0. The block is in OFF on the next clock. A later enable restarts with WAKE and a ramp from 0.
- R6: While `supply_ok`=0, the block is held in OFF (`sw_allow`=0, `dis_en`=1), whatever the state of enable. A drop of `supply_ok` during operation disables switching in that same cycle.
- R7: `over_temp`=1 stops switching in the same cycle and puts the block in HOT on the next clock (`dis_en`=1, `ref_code`=0). OFF does not leave while `over_temp`=1. On the clock after `over_temp` returns to 0 in HOT, switching resumes in RAMP with the code at 0, without a second WAKE.
- R8: `osc_div3` equals `fb_low` while `sw_allow`=1 and is 0 otherwise.
- R9: `sw_allow` and `dis_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Asynchronous enable pin |
| supply_ok | input | 1 | 1 when input supply is above the lockout threshold |
| over_temp | input | 1 | 1 while the die is over temperature (hysteresis upstream) |
| fb_low | input | 1 | 1 while feedback is below the short-circuit level |
| ref_code | output | REF_BITS | Digital loop reference code |
| sw_allow | output | 1 | Power stage may switch |
| dis_en | output | 1 | Output discharge path on |
| osc_div3 | output | 1 | Oscillator runs at one third of nominal frequency |

## Verification
The hardest situation to reach from the ports is a thermal trip after the ramp has completed. It must be shown that the block restarts from a zero code rather than resuming at full scale, and that it skips the wake phase. The stimulus first holds the block in RAMP for 1100 clocks until the code is seen saturated in RUN, raises `over_temp` for one clock, then clears it and checks for code 0 with switching allowed one clock later. The exact wake length is checked by sampling the last WAKE cycle and the first RAMP cycle separately.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_WAKE = 3'd1,
        ST_RAMP = 3'd2,
        ST_RUN  = 3'd3,
        ST_HOT  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/seq_ramp.sv
module seq_ramp #(
    parameter int REF_BITS  = 8,
    parameter int STEP_CLKS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                advance,
    output logic [REF_BITS-1:0] code,
    output logic                at_full
);
    localparam int PRE_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [REF_BITS-1:0] FULL = {REF_BITS{1'b1}};
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CLKS - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            code  <= '0;
        end else if (clear) begin
            pre_q <= '0;
            code  <= '0;
        end else if (advance) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (code != FULL) code <= code + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign at_full = (code == FULL);

    // R3: the code moves by at most one step per clock while ramping
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && $past(advance) && !$past(clear)) |->
            (code == $past(code) || code == $past(code) + 1'b1));
endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
    import seq_pkg::*;
#(
    parameter int REF_BITS  = 8,
    parameter int STEP_CLKS = 4,
    parameter int WAKE_CLKS = 8,
    parameter int SYNC_FF   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_pin,
    input  logic                supply_ok,
    input  logic                over_temp,
    input  logic                fb_low,
    output logic [REF_BITS-1:0] ref_code,
    output logic                sw_allow,
    output logic                dis_en,
    output logic                osc_div3
);
    localparam int WAKE_W = (WAKE_CLKS > 1) ? $clog2(WAKE_CLKS) : 1;
    localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(WAKE_CLKS - 1);

    seq_state_t        state_q, state_d;
    logic              en_s;
    logic              run_ok;
    logic [WAKE_W-1:0] wake_q;
    logic [REF_BITS-1:0] ramp_code;
    logic              ramp_full;
    logic              ramp_clear;

    seq_sync #(.STAGES(SYNC_FF)) u_en_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (en_pin),
        .dout  (en_s)
    );

    assign ramp_clear = !(state_q == ST_RAMP || state_q == ST_RUN);

    seq_ramp #(.REF_BITS(REF_BITS), .STEP_CLKS(STEP_CLKS)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ramp_clear),
        .advance (state_q == ST_RAMP),
        .code    (ramp_code),
        .at_full (ramp_full)
    );

    assign run_ok = en_s && supply_ok && !over_temp;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // wake timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  wake_q <= '0;
        else if (state_q != ST_WAKE) wake_q <= '0;
        else                         wake_q <= wake_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_ok) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (!en_s || !supply_ok)     state_d = ST_OFF;
                else if (over_temp)          state_d = ST_HOT;
                else if (wake_q == WAKE_LAST) state_d = ST_RAMP;
            end
            ST_RAMP: begin
                if (!en_s || !supply_ok) state_d = ST_OFF;
                else if (over_temp)      state_d = ST_HOT;
                else if (ramp_full)      state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en_s || !supply_ok) state_d = ST_OFF;
                else if (over_temp)      state_d = ST_HOT;
            end
            ST_HOT: begin
                if (!en_s || !supply_ok) state_d = ST_OFF;
                else if (!over_temp)     state_d = ST_RAMP;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        sw_allow = (state_q == ST_RAMP || state_q == ST_RUN) && run_ok;
        dis_en   = !(sw_allow || (state_q == ST_WAKE && run_ok));
        osc_div3 = sw_allow && fb_low;
        ref_code = sw_allow ? ramp_code : '0;
    end

    // R9: switching and discharge exclusive
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_allow && dis_en));

    // R7: over-temperature lands in a shutdown state on the next clock
    p_hot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> (state_q == ST_HOT || state_q == ST_OFF));

    // R2: the ramp is entered only from the wake phase or a thermal restart
    p_ramp_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && $past(state_q) != ST_RAMP) |->
            ($past(state_q) == ST_WAKE || $past(state_q) == ST_HOT));

    // R4: the run state always holds a saturated code
    p_run_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ramp_full);

    // R3: reference never falls while switching continues
    p_code_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_allow && $past(sw_allow) && $past(state_q) != ST_HOT) |->
            ref_code >= $past(ref_code));

    // R1: shutdown never allows switching
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (!sw_allow && ref_code == '0));
endmodule

// File: tb/buck_seq_ctrl_tb_top.sv
module buck_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 27;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_pin = 1'b0;
    logic       supply_ok = 1'b1;
    logic       over_temp = 1'b0;
    logic       fb_low = 1'b0;
    logic [7:0] ref_code;
    logic       sw_allow, dis_en, osc_div3;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    buck_seq_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_pin    (en_pin),
        .supply_ok (supply_ok),
        .over_temp (over_temp),
        .fb_low    (fb_low),
        .ref_code  (ref_code),
        .sw_allow  (sw_allow),
        .dis_en    (dis_en),
        .osc_div3  (osc_div3)
    );

    // layout: [31]en [30]supply [29]hot [28]fb [27:16]clocks
    //         [15]sw [14]dis [13]div3 [11:8]requirement [7:0]code
    function automatic logic [31:0] mk(input logic en, input logic uv,
                                       input logic hot, input logic fb,
                                       input int w, input logic sw,
                                       input logic dis, input logic dv,
                                       input int req, input int code);
        return {en, uv, hot, fb, 12'(w), sw, dis, dv, 1'b0, 4'(req), 8'(code)};
    endfunction

    localparam logic [31:0] VEC [NVEC] = '{
        mk(0,1,0,0,   5, 0,1,0, 1,   0), // R1 stays off
        mk(1,1,0,0,   5, 0,0,0, 2,   0), // R2 wake phase
        mk(1,1,0,0,  20, 1,0,0, 3,   3), // R3 code 3
        mk(1,1,0,1,   1, 1,0,1, 8,   3), // R8 slow clock
        mk(1,1,0,0,   1, 1,0,0, 3,   4), // R3 step to 4
        mk(0,1,0,0,   2, 0,1,0, 5,   0), // R5 synced low stops
        mk(0,1,0,0,   1, 0,1,0, 5,   0), // R5 off
        mk(1,1,0,0,  30, 1,0,0, 5,   4), // R5 restart from 0
        mk(1,1,1,0,   1, 0,1,0, 7,   0), // R7 trip
        mk(1,1,1,0,  10, 0,1,0, 7,   0), // R7 held
        mk(1,1,0,0,   1, 1,0,0, 7,   0), // R7 restart no wake
        mk(1,1,0,0,   8, 1,0,0, 3,   2), // R3 code 2
        mk(1,0,0,0,   1, 0,1,0, 6,   0), // R6 lockout
        mk(1,1,0,0,   3, 0,0,0, 2,   0), // R2 wake again
        mk(1,1,1,0,   1, 0,1,0, 7,   0), // R7 trip in wake
        mk(1,1,0,0,   1, 1,0,0, 7,   0), // R7 ramp at 0
        mk(1,1,0,0,1100, 1,0,0, 4, 255), // R4 saturated
        mk(1,1,0,1,   1, 1,0,1, 8, 255), // R8 in run
        mk(1,1,1,0,   1, 0,1,0, 7,   0), // R7 trip from run
        mk(1,1,0,0,   1, 1,0,0, 7,   0), // R7 code back at 0
        mk(0,1,0,0,   3, 0,1,0, 5,   0), // R5 off
        mk(1,0,0,0,  20, 0,1,0, 6,   0), // R6 held off
        mk(1,1,1,0,   5, 0,1,0, 7,   0), // R7 off while hot
        mk(1,1,0,0,   3, 0,0,0, 2,   0), // R2 wake
        mk(1,1,0,0,   5, 0,0,0, 2,   0), // R2 last wake clock
        mk(1,1,0,0,   1, 1,0,0, 2,   0), // R2 first ramp clock
        mk(0,1,0,1,   3, 0,1,0, 8,   0)  // R8 no slow clock when off
    };

    task automatic check(input string what, input int req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("reset sw_allow", 1, int'(sw_allow), 0);
        check("reset dis_en",   1, int'(dis_en),   1);
        check("reset osc_div3", 1, int'(osc_div3), 0);
        check("reset ref_code", 1, int'(ref_code), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            int req;
            v = VEC[i];
            req = int'(v[11:8]);
            @(negedge clk);
            en_pin    = v[31];
            supply_ok = v[30];
            over_temp = v[29];
            fb_low    = v[28];
            repeat (int'(v[27:16])) @(posedge clk);
            #2;
            check($sformatf("row %0d sw_allow", i), req, int'(sw_allow), int'(v[15]));
            check($sformatf("row %0d dis_en",   i), req, int'(dis_en),   int'(v[14]));
            check($sformatf("row %0d osc_div3", i), req, int'(osc_div3), int'(v[13]));
            check($sformatf("row %0d ref_code", i), req, int'(ref_code), int'(v[7:0]));
        end

        // R9 directed: exclusivity observed over a full restart
        @(negedge clk);
        en_pin = 1'b1;
        fb_low = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(posedge clk);
            #2;
            check("sw_allow and dis_en exclusive", 9, int'(sw_allow && dis_en), 0);
        end
        finish_run();
    end
endmodule